// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a memory-mapped watchdog. Software loads an 8-bit count, picks a prescaler code and starts the timer. The count then climbs by one on each prescaled tick. When it wraps from 0xFF to 0x00 the block latches an overflow flag. If watchdog mode and the reset enable are both set, it also drives a system-reset request for a fixed number of clock cycles. Software keeps the system alive by reloading the count before the wrap.

Each register write must carry a key in its upper byte, so a stray store cannot stop or retune the timer. The overflow flag is cleared by a two-step handshake. The flag must first be read while set. A later write of the exact word 0xA500 to the reset-control register then clears it.

Top module: `wdt_keyed`

## Requirements
- R1: After reset every register reads 0x0000 and `wdt_reset_o` is low.
- R2: A write takes effect only at byte offset 0 (control) with upper byte 0xA5, offset 2 (count) with upper byte 0x5A, or offset 4 (reset-control) with upper byte 0x5A. The exact word 0xA500 at offset 4 is the clear request. Any other write, including any write to another offset, changes no state.
- R3: Reads need no key and return 0 in bits 15:8. Control reads back bit 6 = watchdog mode, bit 5 = count enable and bits [CKS_W-1:0] = prescaler code. Count reads back the 8-bit count in bits 7:0. Reset-control reads back bit 7 = overflow flag and bit 6 = reset enable.
- R4: While enabled, the count rises by one per prescaled tick. Loading L gives 256-L ticks before the wrap to 0x00, and the wrap sets the overflow flag.
- R5: Prescaler code c divides the clock by 2^floor(c*MAX_SHIFT/MAX_CODE). MAX_SHIFT is 14 when CKS_W is 3 and 22 when CKS_W is 4. Code 0 divides by 1, and with CKS_W = 3, code 1 divides by 4 and code 2 by 16. A write to the count restarts the prescaler from zero.
- R6: A wrap with watchdog mode and reset enable both set raises `wdt_reset_o` on the same clock edge for exactly PULSE_LEN cycles. Without both bits set, no pulse is produced.
- R7: Clearing the enable bit with a keyed control write stops the count at its current value.
- R8: The word 0xA500 at offset 4 clears the flag only if the flag was read while set since it was last set. Without that read the flag stays set.
- R9: When a wrap and an armed clear request fall on the same clock edge, the flag stays set and the earlier read no longer counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write word, key in bits 15:8 |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read word, valid while `bus_re` is high |
| wdt_reset_o | output | 1 | System-reset request pulse |

## Verification
The counter wrap and the flag-clear write are the two functions that can land on the same edge. The bench first arms the clear by reading the set flag. It then loads 0xFE, starts the count at divide-by-1 and issues the 0xA500 write two edges after the start, which is exactly the edge on which the count passes 0xFF. It judges the outcome by reading the flag afterwards: it must still be set, because a new overflow outranks a clear that was armed for the previous one.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0]  KEY_CTRL = 8'hA5;
  localparam logic [7:0]  KEY_CNT  = 8'h5A;
  localparam logic [7:0]  KEY_RCTL = 8'h5A;
  localparam logic [15:0] CLR_WORD = 16'hA500;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_CNT  = 3'd2;
  localparam logic [2:0] OFS_RCTL = 3'd4;

  // Exponent of the power-of-two divider chosen by a prescaler code.
  function automatic int unsigned div_shift(int unsigned code, int unsigned max_code,
                                            int unsigned max_shift);
    return (code * max_shift) / max_code;
  endfunction
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile import wdt_pkg::*; #(
  parameter int CKS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [7:0]       count,
  input  logic             ovf_event,
  output logic             wt,
  output logic             tme,
  output logic [CKS_W-1:0] cks,
  output logic             rste,
  output logic             load,
  output logic [7:0]       load_val,
  output logic             ovf_flag,
  output logic             clr_ok,
  output logic [15:0]      bus_rdata
);
  logic wr_ctrl, wr_rctl, clr_req, rd_flag, seen_q;

  assign wr_ctrl  = bus_we && bus_addr == OFS_CTRL && bus_wdata[15:8] == KEY_CTRL;
  assign load     = bus_we && bus_addr == OFS_CNT  && bus_wdata[15:8] == KEY_CNT;
  assign wr_rctl  = bus_we && bus_addr == OFS_RCTL && bus_wdata[15:8] == KEY_RCTL;
  assign clr_req  = bus_we && bus_addr == OFS_RCTL && bus_wdata == CLR_WORD;
  assign clr_ok   = clr_req && seen_q && ovf_flag;
  assign rd_flag  = bus_re && bus_addr == OFS_RCTL && ovf_flag;
  assign load_val = bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wt   <= 1'b0;
      tme  <= 1'b0;
      cks  <= '0;
      rste <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        wt  <= bus_wdata[6];
        tme <= bus_wdata[5];
        cks <= bus_wdata[CKS_W-1:0];
      end
      if (wr_rctl) rste <= bus_wdata[6];
    end
  end

  // Flag and its read-arming bit; a fresh overflow outranks a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      seen_q   <= 1'b0;
    end else if (ovf_event) begin
      ovf_flag <= 1'b1;
      seen_q   <= 1'b0;
    end else if (clr_ok) begin
      ovf_flag <= 1'b0;
      seen_q   <= 1'b0;
    end else if (rd_flag) begin
      seen_q   <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        OFS_CTRL: begin
          bus_rdata[6]         = wt;
          bus_rdata[5]         = tme;
          bus_rdata[CKS_W-1:0] = cks;
        end
        OFS_CNT:  bus_rdata[7:0] = count;
        OFS_RCTL: begin
          bus_rdata[7] = ovf_flag;
          bus_rdata[6] = rste;
        end
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler import wdt_pkg::*; #(
  parameter int CKS_W     = 3,
  parameter int MAX_SHIFT = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CKS_W-1:0] cks,
  output logic             tick
);
  localparam int MAX_CODE = (1 << CKS_W) - 1;
  localparam int PRE_W    = MAX_SHIFT;

  logic [PRE_W-1:0] pre_q;
  logic [31:0]      shift, mask32;
  logic [PRE_W-1:0] mask;

  assign shift  = div_shift(32'(cks), MAX_CODE, MAX_SHIFT);
  assign mask32 = (32'd1 << shift) - 32'd1;
  assign mask   = mask32[PRE_W-1:0];
  assign tick   = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (run)     pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       tick,
  output logic [7:0] count,
  output logic       ovf_event
);
  assign ovf_event = tick && !load && count == 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= count + 8'd1;
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic pulse_o
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  logic [CW-1:0] left_q;

  assign pulse_o = left_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (trigger) left_q <= CW'(PULSE_LEN);
    else if (pulse_o) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int CKS_W     = 3,
  parameter int PULSE_LEN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic        bus_we,
  input  logic        bus_re,
  output logic [15:0] bus_rdata,
  output logic        wdt_reset_o
);
  localparam int MAX_SHIFT = (CKS_W >= 4) ? 22 : 14;

  logic             wt, tme, rste, load, ovf_flag, clr_ok, tick, ovf_event, rst_trig;
  logic [CKS_W-1:0] cks;
  logic [7:0]       count, load_val;

  assign rst_trig = ovf_event && wt && rste;

  wdt_regfile #(.CKS_W(CKS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .count(count), .ovf_event(ovf_event),
    .wt(wt), .tme(tme), .cks(cks), .rste(rste), .load(load), .load_val(load_val),
    .ovf_flag(ovf_flag), .clr_ok(clr_ok), .bus_rdata(bus_rdata)
  );

  wdt_prescaler #(.CKS_W(CKS_W), .MAX_SHIFT(MAX_SHIFT)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(tme), .restart(load), .cks(cks), .tick(tick)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .tick(tick),
    .count(count), .ovf_event(ovf_event)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trigger(rst_trig), .pulse_o(wdt_reset_o)
  );
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int CKS_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [2:0]       bus_addr,
  input logic [7:0]       bus_key,
  input logic             wt,
  input logic             tme,
  input logic [CKS_W-1:0] cks,
  input logic             rste,
  input logic             load,
  input logic [7:0]       count,
  input logic             ovf_event,
  input logic             ovf_flag,
  input logic             clr_ok,
  input logic             pulse_o
);
  // R2
  bad_key_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0 && bus_key != 8'hA5) |=> ($stable(wt) && $stable(tme) && $stable(cks)));
  // R4
  ovf_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> ovf_flag);
  // R6
  pulse_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_event && wt && rste) |=> pulse_o);
  // R6
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(ovf_event && wt && rste));
  // R7
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tme && !load) |=> $stable(count));
  // R8
  flag_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(clr_ok));
  // R9
  ovf_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_event && clr_ok) |=> ovf_flag);
endmodule

bind wdt_keyed wdt_keyed_chk #(.CKS_W(CKS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_key(bus_wdata[15:8]), .wt(wt), .tme(tme), .cks(cks), .rste(rste),
  .load(load), .count(count), .ovf_event(ovf_event), .ovf_flag(ovf_flag),
  .clr_ok(clr_ok), .pulse_o(wdt_reset_o)
);

// File: tb/test_wdt_keyed.sv
module test_wdt_keyed;
  localparam int PULSE_LEN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic        wdt_reset_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  wdt_keyed #(.CKS_W(3), .PULSE_LEN(PULSE_LEN)) i_wdt_keyed (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .wdt_reset_o(wdt_reset_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cycles_to_reset(int max, output int n);
    n = 0;
    for (int i = 1; i <= max; i++) begin
      @(negedge clk);
      if (wdt_reset_o) begin n = i; break; end
    end
  endtask

  task automatic t_reset_state();
    logic [15:0] d;
    do_reset();
    rd(3'd0, d); check("R1 control", d, 0);
    rd(3'd2, d); check("R1 count", d, 0);
    rd(3'd4, d); check("R1 reset-control", d, 0);
    check("R1 reset output", wdt_reset_o, 0);
  endtask

  task automatic t_keys();
    logic [15:0] d;
    do_reset();
    wr(3'd0, 16'h1265);
    wr(3'd2, 16'h1277);
    wr(3'd4, 16'h1240);
    wr(3'd6, 16'hA565);
    wr(3'd1, 16'h5A77);
    wr(3'd4, 16'hA540);
    rd(3'd0, d); check("R2 bad key control", d, 0);
    rd(3'd2, d); check("R2 bad key count", d, 0);
    rd(3'd4, d); check("R2 bad key reset-control", d, 0);
  endtask

  task automatic t_readback();
    logic [15:0] d;
    do_reset();
    wr(3'd0, 16'hA545);
    wr(3'd2, 16'h5A3C);
    wr(3'd4, 16'h5A40);
    rd(3'd0, d); check("R3 control layout", d, 16'h0045);
    rd(3'd2, d); check("R3 count layout", d, 16'h003C);
    rd(3'd4, d); check("R3 reset-control layout", d, 16'h0040);
  endtask

  task automatic t_overflow();
    logic [15:0] d;
    int n, hi;
    do_reset();
    wr(3'd4, 16'h5A40);
    wr(3'd2, 16'h5AFD);
    wr(3'd0, 16'hA560);
    cycles_to_reset(20, n);
    check("R4 ticks to wrap from 0xFD", n, 3);
    hi = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (wdt_reset_o) hi++; else break;
    end
    check("R6 pulse length", hi, PULSE_LEN);
    wr(3'd0, 16'hA540);
    rd(3'd4, d); check("R4 flag set after wrap", d, 16'h00C0);
  endtask

  task automatic t_prescale();
    int n;
    do_reset();
    wr(3'd4, 16'h5A40);
    wr(3'd2, 16'h5AFE);
    wr(3'd0, 16'hA561);
    cycles_to_reset(40, n);
    check("R5 code 1 divide by 4", n, 8);
    do_reset();
    wr(3'd4, 16'h5A40);
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA562);
    cycles_to_reset(60, n);
    check("R5 code 2 divide by 16", n, 16);
  endtask

  task automatic t_stop();
    logic [15:0] d;
    do_reset();
    wr(3'd2, 16'h5A10);
    wr(3'd0, 16'hA520);
    repeat (5) @(negedge clk);
    wr(3'd0, 16'hA500);
    repeat (10) @(negedge clk);
    rd(3'd2, d); check("R7 count held after stop", d, 16'h0016);
  endtask

  task automatic t_no_pulse();
    logic [15:0] d;
    int n;
    do_reset();
    wr(3'd2, 16'h5AFD);
    wr(3'd0, 16'hA560);
    cycles_to_reset(10, n);
    check("R6 no pulse without reset enable", n, 0);
    wr(3'd0, 16'hA540);
    rd(3'd4, d); check("R6 flag without reset enable", d, 16'h0080);
    do_reset();
    wr(3'd4, 16'h5A40);
    wr(3'd2, 16'h5AFD);
    wr(3'd0, 16'hA520);
    cycles_to_reset(10, n);
    check("R6 no pulse outside watchdog mode", n, 0);
  endtask

  task automatic make_flag();
    do_reset();
    wr(3'd2, 16'h5AFD);
    wr(3'd0, 16'hA520);
    repeat (6) @(negedge clk);
    wr(3'd0, 16'hA500);
  endtask

  task automatic t_clear();
    logic [15:0] d;
    make_flag();
    wr(3'd4, 16'hA500);
    rd(3'd4, d); check("R8 clear without prior read ignored", d, 16'h0080);
    wr(3'd4, 16'hA500);
    rd(3'd4, d); check("R8 clear after read", d, 16'h0000);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    make_flag();
    rd(3'd4, d); check("R9 flag armed by read", d, 16'h0080);
    wr(3'd2, 16'h5AFE);
    wr(3'd0, 16'hA520);
    @(negedge clk);
    wr(3'd4, 16'hA500);
    wr(3'd0, 16'hA500);
    rd(3'd4, d); check("R9 wrap beats clear", d, 16'h0080);
  endtask

  initial begin
    t_reset_state();
    t_keys();
    t_readback();
    t_overflow();
    t_prescale();
    t_stop();
    t_no_pulse();
    t_clear();
    t_collision();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule